// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block times every interval that an I2C bus sequencer needs in order to place its SCL and SDA edges: the SCL low and high half-periods, the setup and hold of START, the setup of STOP, the data setup and hold, and the release time before a repeated START. The sequencer asks for one interval at a time. It pulses `start` with a phase code, then waits for the single-cycle `done` strobe. While the interval runs, `tick` pulses once for each prescaled time unit.

All counts are in prescaled ticks. One tick lasts DIV+1 input clocks, and DIV is shared by every count of the active set. Two independent timing sets exist, one for fast mode and one for high-speed mode. `hs_sel` chooses between them when an interval starts. This lets a high-speed transfer begin on the fast set and move to the high-speed set later. The data-hold count and the glitch-filter count are common to both sets.

The SCL half-periods carry extra input clocks. Each half gets 4 clocks of synchronizer overhead, which gives the fixed 8 clocks per bit. The filter term gives either 2·FLT per bit (normal mode) or 1·FLT per bit (`alt_filter` mode).

The controller has three states:
- ST_IDLE: waiting for a request.
- ST_TICKS: counting prescaled ticks.
- ST_EXTRA: counting overhead clocks.

Its transitions are:
- IDLE→TICKS on `start`.
- TICKS→IDLE on the last tick when there is no overhead.
- TICKS→EXTRA on the last tick when overhead remains.
- EXTRA→IDLE when the last overhead clock ends.

Top module: `scl_timing_gen`

## Requirements
- R1: During and after reset, `busy`, `tick` and `done` are low.
- R2: A `start` seen in ST_IDLE makes `busy` high after that edge. A `start` raised while `busy` is high is ignored: the running interval keeps its length and produces exactly one `done`.
- R3: With `alt_filter`=0, an SCL low (phase 0) or SCL high (phase 1) interval lasts (DIV+1)·(t+1) + 4 + FLT input clocks.
- R4: With `alt_filter`=1, an SCL low interval lasts (DIV+1)·(t+1) + 4 + FLT clocks, and an SCL high interval lasts (DIV+1)·(t+1) + 4 clocks.
- R5: The phases 2 start-setup, 3 start-hold, 4 stop-setup, 5 data-setup, 6 data-hold and 7 repeated-start release each last (DIV+1)·(t+1) clocks, with no overhead.
- R6: The counts come from fixed bit positions in the timing words:
  - word1: start setup in [31:24], start hold in [23:16], stop setup in [15:8];
  - word2: data setup in [31:24], SCL low in [15:8], SCL high in [7:0];
  - word3: DIV in [23:16], release in [7:0];
  - `hold_word`: data hold in [7:0];
  - `conf_word`: FLT in [18:16].
- R7: `hs_sel`=0 uses the fast words and 1 uses the high-speed words. The choice is sampled at `start`, so a change during an interval has no effect on it.
- R8: An interval produces exactly t+1 `tick` pulses.
- R9: `done` is high for one cycle, in the same cycle that `busy` falls.
- R10: With DIV=0 and a count of 0, an interval lasts 1 clock plus any overhead.
- R11: The longest case, DIV=255 with a count of 255 and FLT=7, lasts 65547 clocks in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_word1 | input | 32 | Fast set: start setup, start hold, stop setup |
| fs_word2 | input | 32 | Fast set: data setup, SCL low, SCL high |
| fs_word3 | input | 32 | Fast set: DIV and release |
| hs_word1 | input | 32 | High-speed set, layout as fs_word1 |
| hs_word2 | input | 32 | High-speed set, layout as fs_word2 |
| hs_word3 | input | 32 | High-speed set, layout as fs_word3 |
| hold_word | input | 32 | Data hold count in [7:0] |
| conf_word | input | 32 | Filter cycle count in [18:16] |
| alt_filter | input | 1 | 1: filter added once per bit |
| hs_sel | input | 1 | Timing set select, sampled at start |
| start | input | 1 | Interval request |
| phase | input | 3 | Phase code 0..7 per R3–R5 |
| busy | output | 1 | Interval in progress |
| tick | output | 1 | One pulse per prescaled tick |
| done | output | 1 | Interval finished |

## Verification
The bench builds the block with its defaults: 32-bit words, 8-bit counts, a 3-bit filter field and 4 overhead clocks per half-period.

Random intervals keep DIV below 4 so that many of them fit in the run, while the counts range over the full 8 bits. The 8-bit field width is what makes the DIV=255, count=255 directed case of 65547 clocks reachable in a single run.

Directed cases add the all-zero interval, stray requests while busy, and a set switch during an interval.

// File: rtl/sclt_pkg.sv
package sclt_pkg;
    typedef enum logic [2:0] {
        PH_SCL_LOW  = 3'd0,
        PH_SCL_HIGH = 3'd1,
        PH_START_SU = 3'd2,
        PH_START_HD = 3'd3,
        PH_STOP_SU  = 3'd4,
        PH_DATA_SU  = 3'd5,
        PH_DATA_HD  = 3'd6,
        PH_SR_REL   = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TICKS = 2'd1,
        ST_EXTRA = 2'd2
    } state_e;

    localparam int FLT_LSB = 16;
endpackage

// File: rtl/sclt_param_mux.sv
module sclt_param_mux
    import sclt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8,
    parameter int FLT_W  = 3,
    parameter int OVH    = 4,
    parameter int EXT_W  = 4
) (
    input  logic [WORD_W-1:0] w1 [2],
    input  logic [WORD_W-1:0] w2 [2],
    input  logic [WORD_W-1:0] w3 [2],
    input  logic [WORD_W-1:0] hold_word,
    input  logic [WORD_W-1:0] conf_word,
    input  logic              alt_filter,
    input  logic              hs_sel,
    input  logic [2:0]        phase,
    output logic [CNT_W-1:0]  div,
    output logic [CNT_W-1:0]  count,
    output logic [EXT_W-1:0]  extra
);
    logic [CNT_W-1:0] set_div [2];
    logic [CNT_W-1:0] set_cnt [2];
    logic [FLT_W-1:0] flt;

    assign flt = conf_word[FLT_LSB +: FLT_W];

    for (genvar g = 0; g < 2; g++) begin : g_set
        assign set_div[g] = w3[g][16 +: CNT_W];
        always_comb begin
            unique case (phase_e'(phase))
                PH_SCL_LOW:  set_cnt[g] = w2[g][8 +: CNT_W];
                PH_SCL_HIGH: set_cnt[g] = w2[g][0 +: CNT_W];
                PH_START_SU: set_cnt[g] = w1[g][24 +: CNT_W];
                PH_START_HD: set_cnt[g] = w1[g][16 +: CNT_W];
                PH_STOP_SU:  set_cnt[g] = w1[g][8 +: CNT_W];
                PH_DATA_SU:  set_cnt[g] = w2[g][24 +: CNT_W];
                PH_DATA_HD:  set_cnt[g] = hold_word[0 +: CNT_W];
                PH_SR_REL:   set_cnt[g] = w3[g][0 +: CNT_W];
                default:     set_cnt[g] = '0;
            endcase
        end
    end

    assign div   = set_div[hs_sel];
    assign count = set_cnt[hs_sel];

    always_comb begin
        extra = '0;
        if (phase_e'(phase) == PH_SCL_LOW)
            extra = EXT_W'(OVH) + EXT_W'(flt);
        else if (phase_e'(phase) == PH_SCL_HIGH)
            extra = EXT_W'(OVH) + (alt_filter ? '0 : EXT_W'(flt));
    end

    logic unused_fields;
    assign unused_fields = ^{w1[0][7:0], w1[1][7:0], w2[0][23:16], w2[1][23:16],
                             w3[0][31:24], w3[0][15:8], w3[1][31:24], w3[1][15:8],
                             hold_word[WORD_W-1:CNT_W], conf_word[WORD_W-1:FLT_LSB+FLT_W],
                             conf_word[FLT_LSB-1:0]};

    always_comb begin
        a_r4_extra_bound : assert (extra <= EXT_W'(OVH + (1 << FLT_W) - 1));
    end
endmodule

// File: rtl/sclt_tick_engine.sv
module sclt_tick_engine
    import sclt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EXT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] div,
    input  logic [CNT_W-1:0] count,
    input  logic [EXT_W-1:0] extra,
    output logic             busy,
    output logic             tick,
    output logic             done
);
    state_e           state, state_n;
    logic [CNT_W-1:0] pre_cnt, tick_cnt, div_q;
    logic [EXT_W-1:0] ext_cnt;
    logic             last_tick;

    assign last_tick = (pre_cnt == '0) && (tick_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_TICKS;
            ST_TICKS: if (last_tick) state_n = (ext_cnt == '0) ? ST_IDLE : ST_EXTRA;
            ST_EXTRA: if (ext_cnt == EXT_W'(1)) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
            div_q    <= '0;
            ext_cnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    pre_cnt  <= div;
                    div_q    <= div;
                    tick_cnt <= count;
                    ext_cnt  <= extra;
                end
                ST_TICKS: begin
                    if (pre_cnt == '0) begin
                        pre_cnt <= div_q;
                        if (tick_cnt != '0) tick_cnt <= tick_cnt - 1'b1;
                    end else begin
                        pre_cnt <= pre_cnt - 1'b1;
                    end
                end
                ST_EXTRA: ext_cnt <= ext_cnt - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
            done <= 1'b0;
        end else begin
            tick <= (state == ST_TICKS) && (pre_cnt == '0);
            done <= ((state == ST_TICKS) && last_tick && (ext_cnt == '0)) ||
                    ((state == ST_EXTRA) && (ext_cnt == EXT_W'(1)));
        end
    end

    assign busy = (state != ST_IDLE);

    a_r2_start_accepted : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    a_r9_done_single : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_with_busy_fall : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r8_tick_inside_interval : assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(busy));
    a_r2_div_held : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8,
    parameter int FLT_W  = 3,
    parameter int OVH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fs_word1,
    input  logic [WORD_W-1:0] fs_word2,
    input  logic [WORD_W-1:0] fs_word3,
    input  logic [WORD_W-1:0] hs_word1,
    input  logic [WORD_W-1:0] hs_word2,
    input  logic [WORD_W-1:0] hs_word3,
    input  logic [WORD_W-1:0] hold_word,
    input  logic [WORD_W-1:0] conf_word,
    input  logic              alt_filter,
    input  logic              hs_sel,
    input  logic              start,
    input  logic [2:0]        phase,
    output logic              busy,
    output logic              tick,
    output logic              done
);
    localparam int EXT_W = $clog2(OVH + (1 << FLT_W));

    logic [WORD_W-1:0] w1 [2];
    logic [WORD_W-1:0] w2 [2];
    logic [WORD_W-1:0] w3 [2];
    logic [CNT_W-1:0]  div, count;
    logic [EXT_W-1:0]  extra;

    assign w1[0] = fs_word1;
    assign w1[1] = hs_word1;
    assign w2[0] = fs_word2;
    assign w2[1] = hs_word2;
    assign w3[0] = fs_word3;
    assign w3[1] = hs_word3;

    sclt_param_mux #(
        .WORD_W(WORD_W), .CNT_W(CNT_W), .FLT_W(FLT_W), .OVH(OVH), .EXT_W(EXT_W)
    ) u_mux (
        .w1(w1), .w2(w2), .w3(w3), .hold_word(hold_word), .conf_word(conf_word),
        .alt_filter(alt_filter), .hs_sel(hs_sel), .phase(phase),
        .div(div), .count(count), .extra(extra)
    );

    sclt_tick_engine #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .div(div), .count(count),
        .extra(extra), .busy(busy), .tick(tick), .done(done)
    );
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] fs1, fs2, fs3, hs1, hs2, hs3, hw, cw;
    logic alt = 1'b0, sel = 1'b0, start = 1'b0;
    logic [2:0] ph = 3'd0;
    logic busy, tick, done;
    int errors = 0, checks = 0;

    always #2 clk = ~clk;

    scl_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .fs_word1(fs1), .fs_word2(fs2), .fs_word3(fs3),
        .hs_word1(hs1), .hs_word2(hs2), .hs_word3(hs3), .hold_word(hw),
        .conf_word(cw), .alt_filter(alt), .hs_sel(sel), .start(start),
        .phase(ph), .busy(busy), .tick(tick), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cnt(input int p, input bit s);
        logic [31:0] a, b, c;
        a = s ? hs1 : fs1;
        b = s ? hs2 : fs2;
        c = s ? hs3 : fs3;
        case (p)
            0: return int'(b[15:8]);
            1: return int'(b[7:0]);
            2: return int'(a[31:24]);
            3: return int'(a[23:16]);
            4: return int'(a[15:8]);
            5: return int'(b[31:24]);
            6: return int'(hw[7:0]);
            default: return int'(c[7:0]);
        endcase
    endfunction

    function automatic int exp_len(input int p, input bit s, input bit al);
        logic [31:0] c;
        int flt, ovh;
        c = s ? hs3 : fs3;
        flt = int'(cw[18:16]);
        ovh = 0;
        if (p == 0) ovh = 4 + flt;
        else if (p == 1) ovh = al ? 4 : 4 + flt;
        return (int'(c[23:16]) + 1) * (exp_cnt(p, s) + 1) + ovh;
    endfunction

    function automatic string tag(input int p, input bit al);
        if (p < 2) return al ? "R4 R6" : "R3 R6";
        return "R5 R6";
    endfunction

    task automatic run(input int p, input bit s, input bit stray, input bit flip);
        int len, ticks, elen, ecnt;
        bit s_at_start;
        elen = exp_len(p, s, alt);
        ecnt = exp_cnt(p, s);
        s_at_start = s;
        @(negedge clk);
        ph = 3'(p);
        sel = s;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        len = 0;
        ticks = 0;
        while (len < 70000) begin
            @(posedge clk);
            len++;
            @(negedge clk);
            if (tick) ticks++;
            if (done) break;
            if (len == 2 && stray) begin
                start = 1'b1;
                ph = 3'(7 - p);
            end else begin
                start = 1'b0;
            end
            if (len == 1 && flip) sel = ~s_at_start;
        end
        start = 1'b0;
        check({tag(p, alt), " length"}, len, elen);
        check("R8 tick count", ticks, ecnt + 1);
        check("R9 busy low at done", int'(busy), 0);
        @(negedge clk);
        check("R9 done one cycle", int'(done), 0);
        if (stray || flip) check("R2 R7 no extra done", int'(busy), 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        fs1 = 0; fs2 = 0; fs3 = 0; hs1 = 0; hs2 = 0; hs3 = 0; hw = 0; cw = 0;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 tick in reset", int'(tick), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);

        // R10: all-zero counts and DIV
        for (int p = 0; p < 8; p++) run(p, 1'b0, 1'b0, 1'b0);
        alt = 1'b1;
        cw = 32'h0005_0000;
        run(1, 1'b0, 1'b0, 1'b0);   // R4 high half without filter
        run(0, 1'b0, 1'b0, 1'b0);   // R4 low half with filter

        // R11: longest interval
        alt = 1'b0;
        cw = 32'h0007_0000;
        fs3 = 32'h00FF_0000;
        fs2 = 32'h0000_00FF;
        run(1, 1'b0, 1'b0, 1'b0);

        // R7: distinct sets and mid-interval switch
        fs3 = 32'h0001_0000; fs2 = 32'h0000_0300;
        hs3 = 32'h0003_0000; hs2 = 32'h0000_0900;
        run(0, 1'b0, 1'b0, 1'b1);
        run(0, 1'b1, 1'b0, 1'b1);

        for (int i = 0; i < 60; i++) begin
            fs1 = $urandom; hs1 = $urandom; fs2 = $urandom; hs2 = $urandom;
            fs3 = ($urandom & 32'hFF00_FFFF) | (($urandom % 4) << 16);
            hs3 = ($urandom & 32'hFF00_FFFF) | (($urandom % 4) << 16);
            hw = $urandom; cw = $urandom;
            alt = 1'($urandom);
            run(int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule